// File: doc/BRIEF.md
# Fully Associative Address Translation Cache with Access Checks

This block caches page translations for a processor pipeline. A virtual address arrives with its access kind (load or store) and the privilege level of the requester. Within the same cycle the upper bits, the virtual page number, are compared against every stored entry at once. On a match the stored physical page number is joined to the untouched page offset to form the physical address. The entry's permission bits are checked before that address is released. A mismatch raises a miss, which tells an external table walker to fetch the translation.

The walker returns its result on a refill port, and the block writes it into one entry. An entry that already holds the same page is overwritten in place. If no entry holds that page, the first empty entry is used. If every entry is in use, a rotating pointer picks the entry to replace. The entries carry no address-space tag, so software clears them all with a flush when it switches address space. A store to a page whose dirty flag is clear is refused, so software can mark the page dirty and retry the store.

Top module: `tlb_top`

## Requirements
- R1: After reset no entry is valid, so every request reports a miss.
- R2: A valid request whose page number matches a valid entry sets hit_o in the same cycle. If the access is allowed, pa_valid_o is 1 and pa_o equals {entry physical page, va_i[PAGE_W-1:0]}. A refill written at one clock edge is visible to lookups in the following cycle.
- R3: A valid request that matches no valid entry sets miss_o and clears hit_o. When req_valid_i is 0, hit_o, miss_o and fault_o are all 0.
- R4: A load (write_i=0) that hits an entry whose read flag is 0 sets fault_o. In that case pa_valid_o is 0 and pa_o is 0.
- R5: A store (write_i=1) faults unless the entry has both its write flag and its dirty flag set. A load is not affected by either flag.
- R6: When user_i is 1, any access to an entry whose user flag is 0 faults. When user_i is 0, the user flag is ignored.
- R7: A refill of a page not already held goes to the lowest-numbered invalid entry whenever one exists.
- R8: When every entry is valid, a refill replaces the entry selected by a pointer. The pointer starts at 0 on reset and advances by one, modulo ENTRIES, on every accepted refill, whichever entry that refill used.
- R9: A refill whose page number matches a valid entry overwrites that entry. No other entry is evicted.
- R10: A flush_i pulse invalidates all entries in one cycle. A refill in the same cycle is dropped, and the replacement pointer keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Lookup request present |
| va_i | input | VA_W | Virtual address |
| write_i | input | 1 | 1 = store, 0 = load |
| user_i | input | 1 | 1 = user level, 0 = kernel level |
| hit_o | output | 1 | Page found in an entry |
| miss_o | output | 1 | Page not found; start a walk |
| fault_o | output | 1 | Access refused by the entry's flags |
| pa_valid_o | output | 1 | pa_o holds a usable address |
| pa_o | output | PA_W | Physical address, 0 unless pa_valid_o |
| flush_i | input | 1 | Invalidate all entries |
| refill_i | input | 1 | Write a translation |
| refill_vpn_i | input | VA_W-PAGE_W | Virtual page number to store |
| refill_ppn_i | input | PA_W-PAGE_W | Physical page number to store |
| refill_r_i | input | 1 | Read flag |
| refill_w_i | input | 1 | Write flag |
| refill_d_i | input | 1 | Dirty flag |
| refill_u_i | input | 1 | User-accessible flag |

## Verification
The bench builds the block with ENTRIES=4, VA_W=16, PA_W=20 and PAGE_W=8. At that size five refills already fill the entries and force an eviction. A flush that lands while the pointer is mid-cycle leaves the pointer at an index away from zero. This separates fill-empty-first from pure rotation, because the two policies evict different pages afterwards. The narrow addresses keep every expected physical address easy to derive by hand.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef struct packed {
    logic r;
    logic w;
    logic d;
    logic u;
  } tlb_perm_t;
endpackage

// File: rtl/tlb_entry.sv
module tlb_entry
  import tlb_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int PPN_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             wr_en_i,
  input  logic [VPN_W-1:0] wr_vpn_i,
  input  logic [PPN_W-1:0] wr_ppn_i,
  input  tlb_perm_t        wr_perm_i,
  input  logic [VPN_W-1:0] lk_vpn_i,
  output logic             valid_o,
  output logic             lk_match_o,
  output logic             wr_match_o,
  output logic [PPN_W-1:0] ppn_o,
  output tlb_perm_t        perm_o
);
  logic             valid_q;
  logic [VPN_W-1:0] vpn_q;
  logic [PPN_W-1:0] ppn_q;
  tlb_perm_t        perm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      vpn_q   <= '0;
      ppn_q   <= '0;
      perm_q  <= '0;
    end else if (flush_i) begin
      valid_q <= 1'b0;
    end else if (wr_en_i) begin
      valid_q <= 1'b1;
      vpn_q   <= wr_vpn_i;
      ppn_q   <= wr_ppn_i;
      perm_q  <= wr_perm_i;
    end
  end

  assign valid_o    = valid_q;
  assign lk_match_o = valid_q && (vpn_q == lk_vpn_i);
  assign wr_match_o = valid_q && (vpn_q == wr_vpn_i);
  assign ppn_o      = ppn_q;
  assign perm_o     = perm_q;
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flush_i,
  input  logic               refill_i,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [ENTRIES-1:0] dup_i,
  output logic [ENTRIES-1:0] sel_o
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [IDX_W-1:0]   ptr_q;
  logic [ENTRIES-1:0] inv_sel, rot_sel;
  logic               inv_found;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (refill_i && !flush_i) begin
      if (ptr_q == IDX_W'(ENTRIES - 1)) ptr_q <= '0;
      else                              ptr_q <= ptr_q + 1'b1;
    end
  end

  // lowest-numbered empty entry
  always_comb begin
    inv_sel   = '0;
    inv_found = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!valid_i[i] && !inv_found) begin
        inv_sel[i] = 1'b1;
        inv_found  = 1'b1;
      end
    end
  end

  always_comb begin
    rot_sel        = '0;
    rot_sel[ptr_q] = 1'b1;
  end

  assign sel_o = (|dup_i) ? dup_i : (inv_found ? inv_sel : rot_sel);
endmodule

// File: rtl/tlb_perm.sv
module tlb_perm
  import tlb_pkg::*;
(
  input  tlb_perm_t perm_i,
  input  logic      write_i,
  input  logic      user_i,
  output logic      allow_o
);
  logic level_ok, kind_ok;

  assign level_ok = !user_i || perm_i.u;
  // store needs dirty already set so software can track modified pages
  assign kind_ok  = write_i ? (perm_i.w && perm_i.d) : perm_i.r;
  assign allow_o  = level_ok && kind_ok;
endmodule

// File: rtl/tlb_top.sv
module tlb_top
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int PAGE_W  = 12
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  input  logic [VA_W-1:0]        va_i,
  input  logic                   write_i,
  input  logic                   user_i,
  output logic                   hit_o,
  output logic                   miss_o,
  output logic                   fault_o,
  output logic                   pa_valid_o,
  output logic [PA_W-1:0]        pa_o,
  input  logic                   flush_i,
  input  logic                   refill_i,
  input  logic [VA_W-PAGE_W-1:0] refill_vpn_i,
  input  logic [PA_W-PAGE_W-1:0] refill_ppn_i,
  input  logic                   refill_r_i,
  input  logic                   refill_w_i,
  input  logic                   refill_d_i,
  input  logic                   refill_u_i
);
  localparam int VPN_W = VA_W - PAGE_W;
  localparam int PPN_W = PA_W - PAGE_W;

  logic [ENTRIES-1:0] valid_vec, lk_match, wr_match, sel;
  logic [PPN_W-1:0]   ppn_arr  [ENTRIES];
  tlb_perm_t          perm_arr [ENTRIES];
  tlb_perm_t          new_perm, hit_perm;
  logic [PPN_W-1:0]   hit_ppn;
  logic               any_match, allow;

  assign new_perm = '{r: refill_r_i, w: refill_w_i, d: refill_d_i, u: refill_u_i};

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    tlb_entry #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_ent (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .flush_i   (flush_i),
      .wr_en_i   (refill_i && sel[g]),
      .wr_vpn_i  (refill_vpn_i),
      .wr_ppn_i  (refill_ppn_i),
      .wr_perm_i (new_perm),
      .lk_vpn_i  (va_i[VA_W-1:PAGE_W]),
      .valid_o   (valid_vec[g]),
      .lk_match_o(lk_match[g]),
      .wr_match_o(wr_match[g]),
      .ppn_o     (ppn_arr[g]),
      .perm_o    (perm_arr[g])
    );
  end

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_i),
    .refill_i(refill_i),
    .valid_i (valid_vec),
    .dup_i   (wr_match),
    .sel_o   (sel)
  );

  // one-hot OR mux over matching entries
  always_comb begin
    hit_ppn  = '0;
    hit_perm = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      hit_ppn  = hit_ppn | ({PPN_W{lk_match[i]}} & ppn_arr[i]);
      hit_perm = hit_perm | ({4{lk_match[i]}} & perm_arr[i]);
    end
  end

  tlb_perm u_perm (
    .perm_i (hit_perm),
    .write_i(write_i),
    .user_i (user_i),
    .allow_o(allow)
  );

  assign any_match  = |lk_match;
  assign hit_o      = req_valid_i && any_match;
  assign miss_o     = req_valid_i && !any_match;
  assign fault_o    = hit_o && !allow;
  assign pa_valid_o = hit_o && allow;
  assign pa_o       = pa_valid_o ? {hit_ppn, va_i[PAGE_W-1:0]} : '0;
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker #(
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int PAGE_W = 12
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   req_valid_i,
  input logic [VA_W-1:0]        va_i,
  input logic                   hit_o,
  input logic                   miss_o,
  input logic                   fault_o,
  input logic                   pa_valid_o,
  input logic [PA_W-1:0]        pa_o,
  input logic                   flush_i,
  input logic                   refill_i,
  input logic [VA_W-PAGE_W-1:0] refill_vpn_i
);
  AST_HIT_MISS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && miss_o)); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> (!hit_o && !miss_o && !fault_o)); // R3

  AST_FAULT_ON_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (hit_o && !pa_valid_o && pa_o == '0)); // R4

  AST_PA_ONLY_ALLOWED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pa_valid_o |-> (hit_o && !fault_o && pa_o[PAGE_W-1:0] == va_i[PAGE_W-1:0])); // R2

  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !hit_o); // R10

  AST_REFILL_VISIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refill_i && !flush_i) |=>
      ((req_valid_i && va_i[VA_W-1:PAGE_W] == $past(refill_vpn_i)) |-> hit_o)); // R2
endmodule

bind tlb_top tlb_checker #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_W(PAGE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .va_i        (va_i),
  .hit_o       (hit_o),
  .miss_o      (miss_o),
  .fault_o     (fault_o),
  .pa_valid_o  (pa_valid_o),
  .pa_o        (pa_o),
  .flush_i     (flush_i),
  .refill_i    (refill_i),
  .refill_vpn_i(refill_vpn_i)
);

// File: tb/sim_tlb_top.sv
module sim_tlb_top;
  localparam int ENTRIES = 4;
  localparam int VA_W    = 16;
  localparam int PA_W    = 20;
  localparam int PAGE_W  = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 0, write_i = 0, user_i = 0, flush_i = 0, refill_i = 0;
  logic [VA_W-1:0] va_i = '0;
  logic [7:0]  refill_vpn_i = '0;
  logic [11:0] refill_ppn_i = '0;
  logic refill_r_i = 0, refill_w_i = 0, refill_d_i = 0, refill_u_i = 0;
  logic hit_o, miss_o, fault_o, pa_valid_o;
  logic [PA_W-1:0] pa_o;

  int checks = 0, errors = 0;

  always #10 clk_i = ~clk_i;

  tlb_top #(.ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .PAGE_W(PAGE_W)) u0 (
    .clk_i, .rst_ni, .req_valid_i, .va_i, .write_i, .user_i,
    .hit_o, .miss_o, .fault_o, .pa_valid_o, .pa_o,
    .flush_i, .refill_i, .refill_vpn_i, .refill_ppn_i,
    .refill_r_i, .refill_w_i, .refill_d_i, .refill_u_i
  );

  task automatic look(input logic [7:0] vpn, input logic [7:0] off, input logic wr,
                      input logic usr, input logic ehit, input logic efault,
                      input logic [11:0] eppn, input string req);
    logic [23:0] act, exp;
    @(negedge clk_i);
    req_valid_i = 1; va_i = {vpn, off}; write_i = wr; user_i = usr;
    #2;
    act = {hit_o, miss_o, fault_o, pa_valid_o, pa_o};
    exp = {ehit, !ehit, efault, ehit && !efault,
           (ehit && !efault) ? {eppn, off} : 20'h0};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s vpn=%h: act=%h exp=%h", req, vpn, act, exp);
    end
    #3 req_valid_i = 0;
  endtask

  task automatic refill(input logic [7:0] vpn, input logic [11:0] ppn,
                        input logic [3:0] rwdu, input logic with_flush);
    @(negedge clk_i);
    refill_i = 1; refill_vpn_i = vpn; refill_ppn_i = ppn;
    {refill_r_i, refill_w_i, refill_d_i, refill_u_i} = rwdu;
    flush_i = with_flush;
    @(negedge clk_i);
    refill_i = 0; flush_i = 0;
  endtask

  task automatic do_flush();
    @(negedge clk_i); flush_i = 1;
    @(negedge clk_i); flush_i = 0;
  endtask

  task automatic t_reset();
    look(8'h12, 8'h34, 0, 0, 0, 0, 12'h0, "R1 reset miss");
    @(negedge clk_i);
    va_i = 16'h1234; req_valid_i = 0; #2;
    checks++;
    if ({hit_o, miss_o, fault_o} !== 3'b000) begin
      errors++;
      $display("FAIL R3 idle: act=%b exp=000", {hit_o, miss_o, fault_o});
    end
  endtask

  task automatic t_basic(); // refill 1 -> entry0, ptr=1
    refill(8'h12, 12'hABC, 4'b1111, 0);
    look(8'h12, 8'h34, 0, 1, 1, 0, 12'hABC, "R2 load hit");
    look(8'h12, 8'hFF, 1, 1, 1, 0, 12'hABC, "R2 store hit");
    look(8'h13, 8'h00, 0, 0, 0, 0, 12'h0, "R3 miss other page");
    @(negedge clk_i); va_i = 16'h1234; req_valid_i = 0; #2;
    checks++;
    if ({hit_o, miss_o, fault_o, pa_valid_o} !== 4'b0000) begin
      errors++;
      $display("FAIL R3 idle with valid entry: act=%b exp=0000",
               {hit_o, miss_o, fault_o, pa_valid_o});
    end
  endtask

  task automatic t_perm(); // refills 2..5, fifth evicts entry0 (0x12)
    refill(8'h20, 12'h111, 4'b0111, 0);
    look(8'h20, 8'h01, 0, 1, 1, 1, 12'h0, "R4 load no read flag");
    look(8'h20, 8'h02, 1, 1, 1, 0, 12'h111, "R5 store allowed");
    refill(8'h21, 12'h121, 4'b1011, 0);
    look(8'h21, 8'h03, 1, 0, 1, 1, 12'h0, "R5 store no write flag");
    refill(8'h22, 12'h131, 4'b1101, 0);
    look(8'h22, 8'h04, 1, 0, 1, 1, 12'h0, "R5 store dirty clear");
    look(8'h22, 8'h05, 0, 1, 1, 0, 12'h131, "R5 load ignores dirty");
    refill(8'h23, 12'h141, 4'b1110, 0);
    look(8'h23, 8'h06, 0, 1, 1, 1, 12'h0, "R6 user on kernel page");
    look(8'h23, 8'h07, 0, 0, 1, 0, 12'h141, "R6 kernel ignores user flag");
    look(8'h12, 8'h00, 0, 0, 0, 0, 12'h0, "R8 full, ptr 0 evicted");
  endtask

  task automatic t_dup(); // refill 6 overwrites entry1, ptr=2
    refill(8'h20, 12'h222, 4'b1111, 0);
    look(8'h20, 8'h10, 0, 1, 1, 0, 12'h222, "R9 overwrite in place");
    look(8'h21, 8'h11, 0, 0, 1, 0, 12'h121, "R9 neighbour kept");
    look(8'h22, 8'h12, 0, 0, 1, 0, 12'h131, "R9 neighbour kept");
    look(8'h23, 8'h13, 0, 0, 1, 0, 12'h141, "R9 neighbour kept");
  endtask

  task automatic t_flush(); // ptr stays 2
    do_flush();
    look(8'h20, 8'h00, 0, 0, 0, 0, 12'h0, "R10 flushed");
    look(8'h23, 8'h00, 0, 0, 0, 0, 12'h0, "R10 flushed");
    refill(8'h30, 12'h300, 4'b1111, 1);
    look(8'h30, 8'h00, 0, 0, 0, 0, 12'h0, "R10 refill during flush dropped");
  endtask

  task automatic t_order();
    // empty entries 0..3 take 0x40..0x43, ptr 2 -> 6 mod 4 = 2
    for (int i = 0; i < 4; i++) refill(8'h40 + 8'(i), 12'h400 + 12'(i), 4'b1111, 0);
    for (int i = 0; i < 4; i++)
      look(8'h40 + 8'(i), 8'h55, 0, 0, 1, 0, 12'h400 + 12'(i), "R7 fill all empty");
    refill(8'h44, 12'h444, 4'b1111, 0); // evicts entry2 = 0x42
    look(8'h40, 8'h01, 0, 0, 1, 0, 12'h400, "R7 empty-first kept 0x40");
    look(8'h42, 8'h01, 0, 0, 0, 0, 12'h0,   "R8 ptr 2 evicted 0x42");
    look(8'h44, 8'h01, 0, 0, 1, 0, 12'h444, "R8 new entry");
    refill(8'h45, 12'h455, 4'b1111, 0); // evicts entry3 = 0x43
    look(8'h43, 8'h02, 0, 0, 0, 0, 12'h0,   "R8 ptr 3 evicted 0x43");
    look(8'h41, 8'h02, 0, 0, 1, 0, 12'h401, "R8 entry1 kept");
    look(8'h45, 8'h02, 0, 0, 1, 0, 12'h455, "R8 new entry");
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    t_reset();
    t_basic();
    t_perm();
    t_dup();
    t_flush();
    t_order();
    repeat (2) @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule